// File: doc/BRIEF.md
# Cartridge ROM Bank Controller

This block maps the 32 KB ROM space of an 8-bit CPU, with its 16-bit address bus, onto a cartridge ROM of up to 2 MB. The lower 16 KB of CPU space is a fixed window that always shows the first 16 KB of the ROM. The upper 16 KB is a switchable window whose ROM bank comes from a set of small control registers.

A CPU write into the ROM space stores no data. Its address picks one of four control registers, and its data loads that register:
- an external-RAM enable flag;
- a 5-bit bank number;
- a 2-bit secondary bank;
- a mode bit that decides whether the secondary bank takes part in the switchable-window address.

A CPU read in the ROM space produces a registered ROM address and a read strobe. The byte returned by the ROM is then registered back to the CPU one cycle later. A bypass input turns the block into a plain no-mapper cartridge: addresses pass straight through and register writes are ignored.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, `ram_en`, `rom_rd` and `rd_valid` are 0, and a read at 0x4000+n produces ROM address 0x4000+n (bank 1, secondary bank 0, mode 0).
- R2: A read at a CPU address in 0x0000–0x3FFF produces a ROM address equal to the CPU address, whatever the register state.
- R3: A write to 0x0000–0x1FFF sets `ram_en` when data bits [3:0] equal 0xA and clears it for any other low nibble; data bits [7:4] are ignored.
- R4: A write to 0x2000–0x3FFF loads the bank register from data bits [4:0]. For a read in 0x4000–0x7FFF, the ROM address bits [18:14] carry that bank and bits [13:0] carry CPU address bits [13:0].
- R5: A bank register value of 0 maps to bank 1 in the switchable window. No other value is altered.
- R6: A write to 0x4000–0x5FFF loads the secondary bank from data bits [1:0]. When the mode bit is 0, it forms ROM address bits [20:19] for switchable-window reads.
- R7: A write to 0x6000–0x7FFF loads the mode bit from data bit 0. When the mode bit is 1, ROM address bits [20:19] are 0 for switchable-window reads.
- R8: Every ROM address bit at or above position ROM_LOG2 is forced to 0, so banks beyond the ROM capacity wrap.
- R9: While `no_mapper` is 1, a read at CPU address A in 0x0000–0x7FFF produces ROM address A[14:0], and writes change no register.
- R10: Accesses with CPU address bit 15 set are ignored: a read raises no `rom_rd`, and a write changes no register.
- R11: `rom_addr` and `rom_rd` are updated one cycle after a read strobe. `cpu_rdata` holds the `rom_rdata` seen in that next cycle, and `rd_valid` is raised one cycle after `rom_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| no_mapper | input | 1 | 1 selects a plain cartridge with no banking |
| rom_addr | output | 21 | Registered ROM byte address |
| rom_rd | output | 1 | Registered ROM read strobe |
| rom_rdata | input | 8 | ROM data for the current `rom_addr` |
| cpu_rdata | output | 8 | Registered read data to the CPU |
| rd_valid | output | 1 | `cpu_rdata` is valid this cycle |
| ram_en | output | 1 | External RAM enable flag |

## Verification
The assertions take it for granted that `cpu_rd` and `cpu_wr` are never high in the same cycle. They also assume that `no_mapper` is steady around any access and that the ROM answers combinationally from `rom_addr`. The bench meets these conditions by driving one strobe at a time on the falling edge, changing `no_mapper` only while idle, and modelling the ROM as a pure function of the address. The switchable-window sweep covers every bank value, every secondary bank value and both modes, with the address of each read varied.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  parameter int BANK_W = 5;
  parameter int SEC_W  = 2;
  parameter int WIN_W  = 14;

  // Register selected by CPU address bits [14:13] on a write.
  typedef enum logic [1:0] {
    SEL_RAMEN = 2'b00,
    SEL_BANK  = 2'b01,
    SEL_SEC   = 2'b10,
    SEL_MODE  = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic              ram_en;
    logic [BANK_W-1:0] bank;
    logic [SEC_W-1:0]  sec;
    logic              mode;
  } bank_state_t;
endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
  import cbc_pkg::*;
#(
  parameter int CPU_AW = 16
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              no_mapper,
  output logic              rd_hit,
  output logic              wr_hit,
  output reg_sel_e          wr_sel
);
  logic in_rom;

  always_comb begin
    in_rom = ~cpu_addr[CPU_AW-1];
    rd_hit = cpu_rd & in_rom;
    wr_hit = cpu_wr & in_rom & ~no_mapper;
    wr_sel = reg_sel_e'(cpu_addr[WIN_W:WIN_W-1]);
  end
endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  reg_sel_e      wr_sel,
  input  logic [DW-1:0] wdata,
  output bank_state_t   state
);
  localparam logic [3:0] ENABLE_KEY = 4'hA;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
    end else if (wr_hit) begin
      unique case (wr_sel)
        SEL_RAMEN: state.ram_en <= (wdata[3:0] == ENABLE_KEY);
        SEL_BANK:  state.bank   <= wdata[BANK_W-1:0];
        SEL_SEC:   state.sec    <= wdata[SEC_W-1:0];
        SEL_MODE:  state.mode   <= wdata[0];
      endcase
    end
  end
endmodule

// File: rtl/cbc_xlate.sv
module cbc_xlate
  import cbc_pkg::*;
#(
  parameter int CPU_AW   = 16,
  parameter int ROM_AW   = 21,
  parameter int ROM_LOG2 = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              no_mapper,
  input  bank_state_t       state,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_rd
);
  localparam int PAD_PLAIN = ROM_AW - (WIN_W + 1);
  localparam int PAD_FIXED = ROM_AW - WIN_W;

  logic [BANK_W-1:0] bank_eff;
  logic [SEC_W-1:0]  sec_eff;
  logic [ROM_AW-1:0] raw_addr;
  logic [ROM_AW-1:0] lim_addr;

  always_comb begin
    bank_eff = (state.bank == '0) ? BANK_W'(1) : state.bank;
    sec_eff  = state.mode ? '0 : state.sec;
    if (no_mapper)
      raw_addr = {{PAD_PLAIN{1'b0}}, cpu_addr[WIN_W:0]};
    else if (!cpu_addr[WIN_W])
      raw_addr = {{PAD_FIXED{1'b0}}, cpu_addr[WIN_W-1:0]};
    else
      raw_addr = ROM_AW'({sec_eff, bank_eff, cpu_addr[WIN_W-1:0]});
  end

  generate
    if (ROM_LOG2 < ROM_AW) begin : g_wrap
      always_comb lim_addr = {{(ROM_AW-ROM_LOG2){1'b0}}, raw_addr[ROM_LOG2-1:0]};
    end else begin : g_full
      always_comb lim_addr = raw_addr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      rom_rd   <= 1'b0;
    end else begin
      rom_rd <= rd_hit;
      if (rd_hit) rom_addr <= lim_addr;
    end
  end
endmodule

// File: rtl/cbc_rdata.sv
module cbc_rdata #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rom_rd,
  input  logic [DW-1:0] rom_rdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= rom_rd;
      if (rom_rd) cpu_rdata <= rom_rdata;
    end
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int CPU_AW   = 16,
  parameter int DW       = 8,
  parameter int ROM_AW   = 21,
  parameter int ROM_LOG2 = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              no_mapper,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_rd,
  input  logic [DW-1:0]     rom_rdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              rd_valid,
  output logic              ram_en
);
  logic        rd_hit;
  logic        wr_hit;
  reg_sel_e    wr_sel;
  bank_state_t state;

  cbc_decode #(.CPU_AW(CPU_AW)) decode_i (
    .cpu_addr (cpu_addr),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .no_mapper(no_mapper),
    .rd_hit   (rd_hit),
    .wr_hit   (wr_hit),
    .wr_sel   (wr_sel)
  );

  cbc_regs #(.DW(DW)) regs_i (
    .clk   (clk),
    .rst   (rst),
    .wr_hit(wr_hit),
    .wr_sel(wr_sel),
    .wdata (cpu_wdata),
    .state (state)
  );

  cbc_xlate #(.CPU_AW(CPU_AW), .ROM_AW(ROM_AW), .ROM_LOG2(ROM_LOG2)) xlate_i (
    .clk      (clk),
    .rst      (rst),
    .rd_hit   (rd_hit),
    .cpu_addr (cpu_addr),
    .no_mapper(no_mapper),
    .state    (state),
    .rom_addr (rom_addr),
    .rom_rd   (rom_rd)
  );

  cbc_rdata #(.DW(DW)) rdata_i (
    .clk      (clk),
    .rst      (rst),
    .rom_rd   (rom_rd),
    .rom_rdata(rom_rdata),
    .cpu_rdata(cpu_rdata),
    .rd_valid (rd_valid)
  );

  assign ram_en = state.ram_en;
endmodule

// File: rtl/cbc_chk.sv
module cbc_chk #(
  parameter int CPU_AW   = 16,
  parameter int DW       = 8,
  parameter int ROM_AW   = 21,
  parameter int ROM_LOG2 = 21
) (
  input logic              clk,
  input logic              rst,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic [DW-1:0]     cpu_wdata,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              no_mapper,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_rd,
  input logic              rd_valid,
  input logic              ram_en
);
  assert_fixed_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[CPU_AW-1:CPU_AW-2] == 2'b00)
      |=> rom_addr == ROM_AW'($past(cpu_addr[13:0])));

  assert_enable_key_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !no_mapper && cpu_addr[CPU_AW-1:CPU_AW-3] == 3'b000
     && cpu_wdata[3:0] == 4'hA) |=> ram_en);

  assert_addr_limit_R8: assert property (@(posedge clk) disable iff (rst)
    ROM_AW'(rom_addr >> ROM_LOG2) == '0);

  assert_bypass_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && no_mapper) |=> $stable(ram_en));

  assert_high_read_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[CPU_AW-1]) |=> !rom_rd);

  assert_high_write_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[CPU_AW-1]) |=> $stable(ram_en));

  assert_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_addr[CPU_AW-1]) |=> rom_rd);

  assert_valid_R11: assert property (@(posedge clk) disable iff (rst)
    rom_rd |=> rd_valid);
endmodule

bind cart_bank_ctrl cbc_chk #(
  .CPU_AW(CPU_AW), .DW(DW), .ROM_AW(ROM_AW), .ROM_LOG2(ROM_LOG2)
) chk_i (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .no_mapper(no_mapper),
  .rom_addr(rom_addr), .rom_rd(rom_rd), .rd_valid(rd_valid), .ram_en(ram_en)
);

// File: tb/cart_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb_top;
  localparam int ROM_LOG2 = 20;
  localparam logic [20:0] MASK = 21'((1 << ROM_LOG2) - 1);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        no_mapper = 1'b0;
  logic [20:0] rom_addr;
  logic        rom_rd;
  logic [7:0]  rom_rdata;
  logic [7:0]  cpu_rdata;
  logic        rd_valid;
  logic        ram_en;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] romf(input logic [20:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b0, a[20:16]};
  endfunction

  assign rom_rdata = romf(rom_addr);

  cart_bank_ctrl #(.ROM_LOG2(ROM_LOG2)) dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .no_mapper(no_mapper),
    .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_rdata(rom_rdata),
    .cpu_rdata(cpu_rdata), .rd_valid(rd_valid), .ram_en(ram_en)
  );

  function automatic logic [20:0] model(input logic [15:0] a, input logic [4:0] bank,
                                        input logic [1:0] sec, input logic mode,
                                        input logic nomap);
    logic [20:0] r;
    if (nomap) r = {6'b0, a[14:0]};
    else if (!a[14]) r = {7'b0, a[13:0]};
    else r = {(mode ? 2'b00 : sec), (bank == 5'd0 ? 5'd1 : bank), a[13:0]};
    return r & MASK;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input logic [20:0] exp, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    check(rom_rd == 1'b1, {tag, " R11 rom_rd"}, int'(rom_rd), 1);
    check(rom_addr == exp, tag, int'(rom_addr), int'(exp));
    @(negedge clk);
    check(rd_valid == 1'b1, {tag, " R11 rd_valid"}, int'(rd_valid), 1);
    check(cpu_rdata == romf(exp), {tag, " R11 data"}, int'(cpu_rdata), int'(romf(exp)));
  endtask

  task automatic set_regs(input logic [4:0] bank, input logic [1:0] sec, input logic mode);
    do_write(16'h2000 | 16'(bank) * 16'h0101, {3'b111, bank});
    do_write(16'h4000 | 16'(sec) * 16'h0044, {6'b111111, sec});
    do_write(16'h6000 | 16'(mode) * 16'h0123, {7'b1010101, mode});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R11 actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(ram_en == 1'b0, "R1 ram_en", int'(ram_en), 0);
    check(rom_rd == 1'b0, "R1 rom_rd", int'(rom_rd), 0);
    check(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    do_read(16'h4005, 21'h004005, "R1 first switch read");

    // R4 R5 R6 R7 R8: full sweep of bank, secondary and mode
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int b = 0; b < 32; b++) begin
          logic [15:0] a;
          a = 16'h4000 | 16'((b * 517 + s * 97 + m * 4099) & 16'h3FFF);
          set_regs(5'(b), 2'(s), 1'(m));
          do_read(a, model(a, 5'(b), 2'(s), 1'(m), 1'b0), "R4 R5 R6 R7 R8 switch");
        end

    // R8: secondary bit 1 lands above ROM_LOG2 and wraps
    set_regs(5'd3, 2'd2, 1'b0);
    do_read(16'h4011, 21'h00C011, "R8 wrap");
    // R5: bank 0 maps to bank 1, with secondary 1
    set_regs(5'd0, 2'd1, 1'b0);
    do_read(16'h7FFF, 21'h087FFF, "R5 zero bank");

    // R2: fixed window ignores register state
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      a = 16'((i * 1031) & 16'h3FFF);
      do_read(a, {7'b0, a[13:0]}, "R2 fixed");
    end

    // R3: every data value to the enable register
    for (int v = 0; v < 256; v++) begin
      do_write(16'((v * 29) & 16'h1FFF), 8'(v));
      check(ram_en == (v[3:0] == 4'hA), "R3 ram_en", int'(ram_en), int'(v[3:0] == 4'hA));
    end

    // R9: bypass mode
    set_regs(5'd5, 2'd1, 1'b0);
    do_write(16'h0000, 8'h0A);
    @(negedge clk); no_mapper = 1'b1;
    do_write(16'h0000, 8'h00);
    check(ram_en == 1'b1, "R9 write ignored", int'(ram_en), 1);
    do_write(16'h2000, 8'h09);
    do_write(16'h6000, 8'h01);
    do_read(16'h4123, 21'h004123, "R9 plain read high");
    do_read(16'h0456, 21'h000456, "R9 plain read low");
    @(negedge clk); no_mapper = 1'b0;
    do_read(16'h4000, 21'h094000, "R9 regs unchanged");

    // R10: high addresses ignored
    do_write(16'h8000, 8'h00);
    check(ram_en == 1'b1, "R10 high write", int'(ram_en), 1);
    do_write(16'hA000, 8'h02);
    do_write(16'hE000, 8'h01);
    do_read(16'h4001, 21'h094001, "R10 high write regs");
    @(negedge clk);
    cpu_addr = 16'hC000; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    check(rom_rd == 1'b0, "R10 high read rom_rd", int'(rom_rd), 0);
    @(negedge clk);
    check(rd_valid == 1'b0, "R10 high read rd_valid", int'(rd_valid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule